// File: doc/BRIEF.md
# Buffered Page Program Sequencer

This block writes a byte range of any length into a page-organised serial flash that has an internal page-sized SRAM buffer. The caller gives the start as a page index plus a byte offset inside that page, a byte count and a pulse on `start`. The payload bytes arrive on a valid/ready stream. The block cuts the range at page boundaries. For each piece (a chunk) it drives serial-bus commands to the device. A chunk that covers less than a full page first has the page loaded from the array into the buffer, so bytes outside the chunk keep their contents. The chunk is then programmed through the buffer. When `cfg_verify` is high, the buffer is compared against the array after the program.

Each command is followed by status polling until the device reports ready. A poll that outlasts a cycle budget, or a compare that reports a difference, stops the range at once. The caller learns the outcome from a one-cycle `done` pulse together with the `error` and `mismatch` levels. The serial bus runs in mode 0 at half the core clock, most significant bit first.

States: IDLE waits for start. PLAN sizes the next chunk. HDR sends an opcode and three address bytes. DATA streams the chunk bytes. RELEASE raises chip select for one cycle. POLL_OP sends the status opcode. POLL_RD reads the status byte. POLL_EVAL judges it. NEXT advances to the next page. FINISH ends the range.

Transitions:
- IDLE→PLAN on start with a non-zero length; IDLE→FINISH on start with zero length.
- PLAN→HDR.
- HDR→DATA after a program header; HDR→RELEASE after a load or compare header.
- DATA→RELEASE after the last chunk byte.
- RELEASE→POLL_OP→POLL_RD→POLL_EVAL.
- POLL_EVAL→POLL_OP while the device is busy.
- POLL_EVAL→HDR after a load, or after a program when verify is on.
- POLL_EVAL→NEXT after a program without verify, or after a clean compare.
- POLL_EVAL→FINISH on timeout or mismatch.
- NEXT→PLAN while bytes remain; NEXT→FINISH when none remain.
- FINISH→IDLE.

Top module: `bufpgm_seq`

## Requirements
- R1: Out of reset the block is idle: `busy`, `done`, `error`, `mismatch`, `din_ready` and `spi_sclk` are 0 and `spi_cs_n` is 1.
- R2: The first chunk runs from the start offset up to the page end, or covers the whole length if that is shorter. Each later chunk is one full page or the remainder. After each chunk the page index rises by one and the offset becomes 0.
- R3: A chunk shorter than `PAGE_BYTES` is preceded by a load command: opcode 0x53, then the 24-bit address `page<<PAGE_SHIFT` with the offset field 0. A full-page chunk gets no load command.
- R4: The program command is opcode 0x82, then the address `(page<<PAGE_SHIFT) | offset` as three bytes (high byte first), then the chunk bytes. Chip select stays low from the opcode through the last data byte.
- R5: After every command the block polls until the device is ready. Each poll is a separate chip-select frame with opcode 0xD7 and one read byte, and bit 7 = 1 of that byte means ready. No further command starts before ready is seen.
- R6: With `cfg_verify` = 1, each program that completes is followed by a compare command: opcode 0x60 with the page address (offset field 0), then polling. If the ready status has bit 6 = 1, the block sets `error` and `mismatch` and issues no further commands.
- R7: With `cfg_verify` = 0, no compare command is sent and status bit 6 has no effect on `error` or `mismatch`.
- R8: If one command's polling lasts more than `TIMEOUT_CYC` cycles without ready, the block sets `error`, leaves `mismatch` at 0 and stops the range.
- R9: `done` pulses for exactly one cycle at the end of every range. `error` and `mismatch` stay valid until the next `start`, which clears them. A zero length ends with `done` and no bus activity.
- R10: `din_ready` is high only while the data of a program command is being sent. Exactly `length` stream bytes are taken per range, and the block waits while `din_valid` is low.
- R11: The bus uses mode 0: `spi_sclk` idles low and toggles only while `spi_cs_n` is low. Bytes go out most significant bit first, at one bus clock per two core clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a range (sampled while idle) |
| cfg_verify | input | 1 | Static: compare each programmed page |
| start_page | input | PAGE_W | Page index of the first byte |
| start_off | input | PAGE_SHIFT | Byte offset of the first byte inside its page |
| length | input | LEN_W | Number of bytes to write |
| din_data | input | 8 | Payload byte |
| din_valid | input | 1 | Payload byte present |
| din_ready | output | 1 | Payload byte taken this cycle |
| busy | output | 1 | Range in progress |
| done | output | 1 | One-cycle end-of-range pulse |
| error | output | 1 | Last range aborted (timeout or mismatch) |
| mismatch | output | 1 | Last range aborted by a compare difference |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
On the last chunk of a verified range, the compare verdict and the end of the range are decided in the same evaluation cycle. A set bit 6 must win and turn the `done` into an errored one, not a clean finish. The bench provokes this with a single-page verified write against a device model that reports a difference. It also does so with a multi-page write, where the model's command counts must show the abort right after the first compare. The busy-poll verdict and the timeout budget likewise meet in that evaluation cycle. A device that never turns ready must end with `error` set and `mismatch` clear, and no command may follow the stuck one.

// File: rtl/bufpgm_pkg.sv
package bufpgm_pkg;
    localparam logic [7:0] OPC_LOAD = 8'h53;
    localparam logic [7:0] OPC_PROG = 8'h82;
    localparam logic [7:0] OPC_CMP  = 8'h60;
    localparam logic [7:0] OPC_STAT = 8'hD7;
    localparam int STAT_RDY_BIT = 7;
    localparam int STAT_DIF_BIT = 6;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PLAN, ST_HDR, ST_DATA, ST_RELEASE,
        ST_POLL_OP, ST_POLL_RD, ST_POLL_EVAL, ST_NEXT, ST_FINISH
    } seq_state_e;

    typedef enum logic [1:0] {
        CK_LOAD, CK_PROG, CK_CMP
    } cmd_kind_e;
endpackage

// File: rtl/bufpgm_spi_byte.sv
module bufpgm_spi_byte (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx,
    output logic       done,
    output logic [7:0] rx,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);
    logic [7:0] sh_q;
    logic [2:0] bit_q;
    logic       active_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q     <= '0;
            bit_q    <= '0;
            active_q <= 1'b0;
            sclk     <= 1'b0;
            done     <= 1'b0;
            rx       <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                sh_q     <= tx;
                bit_q    <= '0;
                active_q <= 1'b1;
                sclk     <= 1'b0;
            end else if (active_q) begin
                if (!sclk) begin
                    sclk <= 1'b1;
                    rx   <= {rx[6:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bit_q == 3'd7) begin
                        active_q <= 1'b0;
                        done     <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                        sh_q  <= {sh_q[6:0], 1'b0};
                    end
                end
            end
        end
    end

    assign mosi = sh_q[7];

    a_r11_go_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !active_q);
    a_r11_sclk_only_active: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> active_q);
endmodule

// File: rtl/bufpgm_chunk_plan.sv
module bufpgm_chunk_plan #(
    parameter int PAGE_BYTES = 264,
    parameter int PAGE_SHIFT = 9,
    parameter int PAGE_W     = 12,
    parameter int LEN_W      = 16
) (
    input  logic [LEN_W-1:0]      remain,
    input  logic [PAGE_W-1:0]     page,
    input  logic [PAGE_SHIFT-1:0] off,
    output logic [LEN_W-1:0]      clen,
    output logic                  partial,
    output logic [23:0]           byte_addr,
    output logic [23:0]           page_addr
);
    localparam logic [LEN_W-1:0] PAGE_LEN = LEN_W'(PAGE_BYTES);

    logic [LEN_W-1:0] room;

    always_comb begin
        room      = PAGE_LEN - LEN_W'(off);
        clen      = (remain < room) ? remain : room;
        partial   = (clen != PAGE_LEN);
        byte_addr = 24'({page, off});
        page_addr = 24'({page, {PAGE_SHIFT{1'b0}}});
    end
endmodule

// File: rtl/bufpgm_poll_timer.sv
module bufpgm_poll_timer #(
    parameter int TIMEOUT_CYC = 500_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic expired
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT_CYC);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (clear)      cnt_q <= '0;
        else if (!expired)   cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q >= LIMIT);

    a_r8_expiry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !clear) |=> expired);
endmodule

// File: rtl/bufpgm_seq.sv
module bufpgm_seq
    import bufpgm_pkg::*;
#(
    parameter int PAGE_BYTES  = 264,
    parameter int PAGE_SHIFT  = 9,
    parameter int PAGE_W      = 12,
    parameter int LEN_W       = 16,
    parameter int TIMEOUT_CYC = 500_000_000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  cfg_verify,
    input  logic [PAGE_W-1:0]     start_page,
    input  logic [PAGE_SHIFT-1:0] start_off,
    input  logic [LEN_W-1:0]      length,
    input  logic [7:0]            din_data,
    input  logic                  din_valid,
    output logic                  din_ready,
    output logic                  busy,
    output logic                  done,
    output logic                  error,
    output logic                  mismatch,
    output logic                  spi_sclk,
    output logic                  spi_cs_n,
    output logic                  spi_mosi,
    input  logic                  spi_miso
);
    localparam logic [LEN_W-1:0] PAGE_LEN = LEN_W'(PAGE_BYTES);

    seq_state_e state_q, state_d;
    cmd_kind_e  kind_q;

    logic [PAGE_W-1:0]     page_q;
    logic [PAGE_SHIFT-1:0] off_q;
    logic [LEN_W-1:0]      remain_q, clen_q, dcnt_q;
    logic [1:0]            idx_q;
    logic                  inflight_q;
    logic [7:0]            stat_q;

    logic                  eng_go, eng_done;
    logic [7:0]            eng_tx, eng_rx;
    logic [LEN_W-1:0]      plan_len;
    logic                  plan_partial;
    logic [23:0]           byte_addr, page_addr, hdr_addr;
    logic                  tmr_clear, tmr_expired;
    logic                  stat_ready, stat_diff;

    bufpgm_chunk_plan #(
        .PAGE_BYTES(PAGE_BYTES), .PAGE_SHIFT(PAGE_SHIFT),
        .PAGE_W(PAGE_W), .LEN_W(LEN_W)
    ) i_plan (
        .remain(remain_q), .page(page_q), .off(off_q),
        .clen(plan_len), .partial(plan_partial),
        .byte_addr(byte_addr), .page_addr(page_addr)
    );

    bufpgm_poll_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_timer (
        .clk(clk), .rst_n(rst_n), .clear(tmr_clear), .expired(tmr_expired)
    );

    bufpgm_spi_byte i_eng (
        .clk(clk), .rst_n(rst_n), .go(eng_go), .tx(eng_tx),
        .done(eng_done), .rx(eng_rx),
        .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
    );

    assign stat_ready = stat_q[STAT_RDY_BIT];
    assign stat_diff  = stat_q[STAT_DIF_BIT];
    assign tmr_clear  = (state_q == ST_RELEASE);
    assign hdr_addr   = (kind_q == CK_PROG) ? byte_addr : page_addr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (start) state_d = (length == '0) ? ST_FINISH : ST_PLAN;
            ST_PLAN:
                state_d = ST_HDR;
            ST_HDR:
                if (inflight_q && eng_done && idx_q == 2'd3)
                    state_d = (kind_q == CK_PROG) ? ST_DATA : ST_RELEASE;
            ST_DATA:
                if (inflight_q && eng_done && dcnt_q == clen_q - 1'b1)
                    state_d = ST_RELEASE;
            ST_RELEASE:
                state_d = ST_POLL_OP;
            ST_POLL_OP:
                if (inflight_q && eng_done) state_d = ST_POLL_RD;
            ST_POLL_RD:
                if (inflight_q && eng_done) state_d = ST_POLL_EVAL;
            ST_POLL_EVAL:
                if (stat_ready) begin
                    unique case (kind_q)
                        CK_LOAD: state_d = ST_HDR;
                        CK_PROG: state_d = cfg_verify ? ST_HDR : ST_NEXT;
                        CK_CMP:  state_d = stat_diff ? ST_FINISH : ST_NEXT;
                        default: state_d = ST_FINISH;
                    endcase
                end else begin
                    state_d = tmr_expired ? ST_FINISH : ST_POLL_OP;
                end
            ST_NEXT:
                state_d = (remain_q == clen_q) ? ST_FINISH : ST_PLAN;
            ST_FINISH:
                state_d = ST_IDLE;
            default:
                state_d = ST_IDLE;
        endcase
    end

    // Outputs toward the byte engine and the stream
    always_comb begin
        eng_go    = 1'b0;
        eng_tx    = 8'h00;
        din_ready = 1'b0;
        unique case (state_q)
            ST_HDR: begin
                eng_go = !inflight_q;
                unique case (idx_q)
                    2'd0: eng_tx = (kind_q == CK_LOAD) ? OPC_LOAD :
                                   (kind_q == CK_PROG) ? OPC_PROG : OPC_CMP;
                    2'd1: eng_tx = hdr_addr[23:16];
                    2'd2: eng_tx = hdr_addr[15:8];
                    default: eng_tx = hdr_addr[7:0];
                endcase
            end
            ST_DATA: begin
                eng_go    = !inflight_q && din_valid;
                din_ready = eng_go;
                eng_tx    = din_data;
            end
            ST_POLL_OP: begin
                eng_go = !inflight_q;
                eng_tx = OPC_STAT;
            end
            ST_POLL_RD: begin
                eng_go = !inflight_q;
                eng_tx = 8'h00;
            end
            default: ;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q     <= '0;
            off_q      <= '0;
            remain_q   <= '0;
            clen_q     <= '0;
            dcnt_q     <= '0;
            idx_q      <= '0;
            kind_q     <= CK_LOAD;
            inflight_q <= 1'b0;
            stat_q     <= '0;
            spi_cs_n   <= 1'b1;
            done       <= 1'b0;
            error      <= 1'b0;
            mismatch   <= 1'b0;
        end else begin
            done     <= (state_q == ST_FINISH);
            spi_cs_n <= !(state_d inside {ST_HDR, ST_DATA, ST_POLL_OP, ST_POLL_RD});
            if (eng_go)        inflight_q <= 1'b1;
            else if (eng_done) inflight_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    page_q   <= start_page;
                    off_q    <= start_off;
                    remain_q <= length;
                    error    <= 1'b0;
                    mismatch <= 1'b0;
                end
                ST_PLAN: begin
                    clen_q <= plan_len;
                    kind_q <= plan_partial ? CK_LOAD : CK_PROG;
                    idx_q  <= '0;
                end
                ST_HDR: if (inflight_q && eng_done) begin
                    idx_q  <= idx_q + 2'd1;
                    dcnt_q <= '0;
                end
                ST_DATA: if (inflight_q && eng_done) dcnt_q <= dcnt_q + 1'b1;
                ST_POLL_RD: if (inflight_q && eng_done) stat_q <= eng_rx;
                ST_POLL_EVAL: begin
                    idx_q <= '0;
                    if (stat_ready) begin
                        if (kind_q == CK_LOAD) kind_q <= CK_PROG;
                        else if (kind_q == CK_PROG && cfg_verify) kind_q <= CK_CMP;
                        else if (kind_q == CK_CMP && stat_diff) begin
                            error    <= 1'b1;
                            mismatch <= 1'b1;
                        end
                    end else if (tmr_expired) begin
                        error <= 1'b1;
                    end
                end
                ST_NEXT: begin
                    remain_q <= remain_q - clen_q;
                    page_q   <= page_q + 1'b1;
                    off_q    <= '0;
                end
                default: ;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);

    a_r2_chunk_fits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PLAN) |-> (plan_len != '0 && plan_len <= PAGE_LEN));
    a_r4_cs_low_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> !spi_cs_n);
    a_r5_cs_high_between_polls: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POLL_EVAL) |-> spi_cs_n);
    a_r6_mismatch_is_error: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |-> error);
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_ready_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
        din_ready |-> !spi_cs_n);
    a_r11_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);
endmodule

// File: tb/test_bufpgm_seq.sv
`timescale 1ns/1ps
module test_bufpgm_seq;
    localparam int PB = 12, SH = 4, PW = 8, LW = 16, TO = 400, NPG = 8;
    localparam logic [7:0] O_LOAD = 8'h53, O_PROG = 8'h82, O_CMP = 8'h60, O_STAT = 8'hD7;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cfg_verify = 1'b0;
    logic [PW-1:0] start_page = '0;
    logic [SH-1:0] start_off = '0;
    logic [LW-1:0] length = '0;
    logic [7:0] din_data = '0;
    logic din_valid = 1'b0, din_ready, busy, done, error, mismatch;
    logic spi_sclk, spi_cs_n, spi_mosi, spi_miso = 1'b0;

    always #2 clk = ~clk;

    bufpgm_seq #(.PAGE_BYTES(PB), .PAGE_SHIFT(SH), .PAGE_W(PW), .LEN_W(LW),
                 .TIMEOUT_CYC(TO)) i_bufpgm_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_verify(cfg_verify),
        .start_page(start_page), .start_off(start_off), .length(length),
        .din_data(din_data), .din_valid(din_valid), .din_ready(din_ready),
        .busy(busy), .done(done), .error(error), .mismatch(mismatch),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso));

    int checks = 0, errors = 0;
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- device model ----------------
    logic [7:0] flash [NPG*PB];
    logic [7:0] expm  [NPG*PB];
    logic [7:0] bufm  [PB];
    int bitpos = 0, busy_left = 0, cfg_busy = 1, stuck = 0, force_mis = 0, dev_busy = 0;
    int n_xfer = 0, n_prog = 0, n_cmp = 0, n_poll = 0, n_txn = 0;
    int n_viol = 0, n_badaddr = 0, n_sclk_bad = 0;
    logic [7:0] shin = '0, m_op = '0, m_stat = '0;
    logic [23:0] m_addr = '0;

    task automatic take_byte(input int n, input logic [7:0] b);
        int pos;
        if (n == 0) begin
            m_op = b; m_addr = '0;
            if (b != O_STAT && dev_busy != 0) n_viol++;
            if (b == O_STAT)
                m_stat = (stuck != 0 || busy_left > 0) ? 8'h00 :
                         (force_mis != 0 ? 8'hC0 : 8'h80);
        end else if (n <= 3) begin
            m_addr = {m_addr[15:0], b};
        end else if (m_op == O_PROG) begin
            pos = int'(m_addr & ((1 << SH) - 1)) + n - 4;
            if (pos < PB) bufm[pos] = b; else n_badaddr++;
        end
    endtask

    always @(negedge spi_cs_n) bitpos = 0;

    always @(posedge spi_sclk) begin
        if (spi_cs_n) n_sclk_bad++;
        else begin
            shin = {shin[6:0], spi_mosi};
            bitpos++;
            if (bitpos % 8 == 0) take_byte(bitpos / 8 - 1, shin);
        end
    end

    always @(negedge spi_sclk)
        if (!spi_cs_n && m_op == O_STAT && bitpos >= 8 && bitpos < 16)
            spi_miso = m_stat[15 - bitpos];

    always @(posedge spi_cs_n) begin
        int pg;
        if (bitpos > 0) begin
            n_txn++;
            pg = int'(m_addr >> SH);
            if (pg >= NPG) n_badaddr++;
            else if (m_op == O_STAT) begin
                n_poll++;
                if (m_stat[7]) dev_busy = 0;
                else if (busy_left > 0) busy_left--;
            end else begin
                dev_busy = 1; busy_left = cfg_busy;
                if (m_op == O_LOAD) begin
                    n_xfer++;
                    if ((m_addr & ((1 << SH) - 1)) != 0) n_badaddr++;
                    for (int i = 0; i < PB; i++) bufm[i] = flash[pg*PB + i];
                end else if (m_op == O_PROG) begin
                    n_prog++;
                    for (int i = 0; i < PB; i++) flash[pg*PB + i] = bufm[i];
                end else if (m_op == O_CMP) begin
                    n_cmp++;
                    if ((m_addr & ((1 << SH) - 1)) != 0) n_badaddr++;
                end else n_badaddr++;
            end
            bitpos = 0;
        end
    end

    // ---------------- payload source ----------------
    logic [7:0] payload [64];
    int hs_cnt = 0, src_len = 0, cyc = 0;
    logic src_clear = 1'b0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (src_clear) hs_cnt <= 0;
        else if (din_valid && din_ready) hs_cnt <= hs_cnt + 1;
    end
    always @(negedge clk) begin
        din_valid = (hs_cnt < src_len) && (cyc % 5 != 2);
        din_data  = payload[hs_cnt % 64];
    end

    // ---------------- sequences ----------------
    bit got_done;
    task automatic run_op(input int pg, input int off, input int len, input int ver,
                          input int seed);
        for (int i = 0; i < NPG*PB; i++) begin
            flash[i] = 8'(i * 7 + 3);
            expm[i]  = flash[i];
        end
        for (int i = 0; i < PB; i++) bufm[i] = 8'hEE;
        for (int k = 0; k < 64; k++) payload[k] = 8'(seed * 37 + k * 5 + 1);
        for (int k = 0; k < len; k++) expm[pg*PB + off + k] = payload[k];
        n_xfer = 0; n_prog = 0; n_cmp = 0; n_poll = 0; n_txn = 0;
        n_viol = 0; n_badaddr = 0; dev_busy = 0; busy_left = 0;
        @(negedge clk);
        src_clear = 1'b1; src_len = len;
        start_page = PW'(pg); start_off = SH'(off); length = LW'(len);
        cfg_verify = ver[0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0; src_clear = 1'b0;
        chk(busy == 1'b1 || len == 0, "R9 busy after start", busy, 1);
        got_done = 0;
        for (int c = 0; c < 20000 && !got_done; c++) begin
            @(negedge clk);
            if (done) got_done = 1;
        end
        chk(got_done, "R9 done seen (watchdog)", got_done, 1);
        chk(busy == 1'b0, "R9 busy low at done", busy, 0);
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", done, 0);
    endtask

    function automatic int mem_diffs();
        int d = 0;
        for (int i = 0; i < NPG*PB; i++) if (flash[i] !== expm[i]) d++;
        return d;
    endfunction

    // page, off, len, verify, busy polls | exp load, exp prog, exp cmp
    localparam int NV = 6;
    localparam int VT [NV][8] = '{
        '{1, 0, 12, 0, 1, 0, 1, 0},
        '{2, 5,  4, 1, 2, 1, 1, 1},
        '{3, 10, 5, 0, 1, 2, 2, 0},
        '{4, 0, 30, 1, 3, 1, 3, 3},
        '{0, 11, 1, 0, 1, 1, 1, 0},
        '{6, 3,  9, 1, 1, 1, 1, 1}
    };

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 0 && done == 0 && error == 0 && mismatch == 0, "R1 status idle",
            {busy, done, error, mismatch}, 0);
        chk(spi_cs_n == 1 && spi_sclk == 0 && din_ready == 0, "R1 bus idle",
            {spi_cs_n, spi_sclk, din_ready}, 4);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            force_mis = 0; stuck = 0; cfg_busy = VT[v][4];
            run_op(VT[v][0], VT[v][1], VT[v][2], VT[v][3], v + 1);
            chk(error == 0 && mismatch == 0, "R9 clean range no error", error, 0);
            chk(mem_diffs() == 0, "R2 R4 flash contents", mem_diffs(), 0);
            chk(n_xfer == VT[v][5], "R3 load count", n_xfer, VT[v][5]);
            chk(n_prog == VT[v][6], "R2 program count", n_prog, VT[v][6]);
            chk(n_cmp == VT[v][7], "R6 R7 compare count", n_cmp, VT[v][7]);
            chk(n_viol == 0, "R5 command only after ready", n_viol, 0);
            chk(n_poll >= (n_xfer + n_prog + n_cmp) * (VT[v][4] + 1), "R5 poll count",
                n_poll, (n_xfer + n_prog + n_cmp) * (VT[v][4] + 1));
            chk(n_badaddr == 0, "R3 R4 address fields", n_badaddr, 0);
            chk(hs_cnt == VT[v][2], "R10 stream bytes taken", hs_cnt, VT[v][2]);
            chk(n_sclk_bad == 0, "R11 sclk only with cs low", n_sclk_bad, 0);
        end

        // R9 zero length: done without bus activity
        run_op(2, 3, 0, 1, 9);
        chk(n_txn == 0 && error == 0, "R9 zero length", n_txn, 0);

        // R6 mismatch on a single verified page: same cycle as range end
        force_mis = 1; cfg_busy = 1;
        run_op(5, 0, 12, 1, 10);
        chk(error == 1 && mismatch == 1, "R6 last-chunk mismatch", {error, mismatch}, 3);

        // R6 abort after first compare of a multi-page range
        run_op(1, 0, 20, 1, 11);
        chk(error == 1 && mismatch == 1, "R6 mismatch flags", {error, mismatch}, 3);
        chk(n_prog == 1 && n_cmp == 1, "R6 abort remaining chunks", n_prog * 10 + n_cmp, 11);

        // R7 verify off ignores bit 6
        run_op(1, 4, 14, 0, 12);
        chk(error == 0 && mismatch == 0, "R7 bit 6 ignored", {error, mismatch}, 0);
        chk(n_cmp == 0 && mem_diffs() == 0, "R7 no compare", n_cmp, 0);

        // R8 timeout on a stuck device
        force_mis = 0; stuck = 1;
        run_op(2, 0, 24, 1, 13);
        chk(error == 1 && mismatch == 0, "R8 timeout flags", {error, mismatch}, 2);
        chk(n_prog == 1 && n_xfer == 0 && n_cmp == 0, "R8 abort after stuck command",
            n_prog + n_xfer + n_cmp, 1);
        chk(n_poll > 2, "R8 polled before giving up", n_poll, 3);
        stuck = 0;

        // R9 next start clears error
        run_op(3, 2, 3, 0, 14);
        chk(error == 0 && mem_diffs() == 0, "R9 error cleared by start", error, 0);
        chk(n_sclk_bad == 0, "R11 sclk idle low overall", n_sclk_bad, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule